// File: doc/BRIEF.md
# USB Host Controller Configuration and Error-Interrupt Register Bank

This block is a small memory-mapped bank of 32-bit registers placed beside a USB host controller. Software reaches it through a simple APB-style slave port (select, enable, write, address, write data, byte strobes, read data and an error flag, with no wait states). Its register contents drive the controller's static configuration: a 4-bit bus-filter bypass, five port control bits, a 6-bit frame-length adjustment, a byte-order select, a coherency select and a bus-master enable.

Two hardware error events (an address-decode error and a host system error) arrive as single-cycle pulses and are latched into a status register that software clears by writing ones. The interrupt mask cannot be written directly. A write to the enable register unmasks the bits set in its data, and a write to the disable register masks them. One registered, level-sensitive interrupt line reports any status bit whose mask bit is clear. A control bit chooses whether an access to an unmapped offset is answered with an error response, which also counts as an address-decode error.

Top module: `usb_host_cfg_regs`

## Requirements
- R1: After reset the bank reads: bus filter 0x00, port 0x00, frame adjust 0x20, byte order 0, coherency 0, bus-master enable 1, register control 0, status 0, mask 0x3, spare 0. The interrupt output is 0.
- R2: The configuration registers are at these offsets: bus filter 0x30 (bits 3:0), port 0x34 (bits 4:0), frame adjust 0x38 (bits 5:0), byte order 0x40 (bit 0), coherency 0x44 (bit 0), bus-master enable 0x48 (bit 0), register control 0x60 (bit 0). Each register reads back what was written, with the bits above its field reading 0. Its value appears on the matching configuration output from the clock edge that completes the write.
- R3: The spare register at 0x78 stores and returns all 32 bits.
- R4: Status at 0x64 holds the address-decode error in bit 0 and the host system error in bit 1. A pulse on errEvent[i] sets bit i. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R5: If an event pulse and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: The mask at 0x68 reads its current value, and a bus write to 0x68 leaves it unchanged.
- R7: A write to 0x6C clears each mask bit whose data bit is 1. A write to 0x70 sets each mask bit whose data bit is 1. Both offsets read as 0.
- R8: irqOut is a register. It is 1 exactly one clock after a cycle in which some status bit is 1 while its mask bit is 0.
- R9: When register control bit 0 is 1, an access to an unmapped offset asserts pSlvErr during the access phase and sets status bit 0. When that bit is 0, the access reads 0 and pSlvErr stays 0.
- R10: A write whose byte strobes are not all ones leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | Slave select |
| pEnable | input | 1 | Access phase marker |
| pWrite | input | 1 | 1 for a write, 0 for a read |
| pAddr | input | ADDR_W | Byte address |
| pWdata | input | 32 | Write data |
| pStrb | input | 4 | Byte strobes; only 4'hF is a valid write |
| pRdata | output | 32 | Read data during a read access phase |
| pSlvErr | output | 1 | Error response during the access phase |
| errEvent | input | 2 | Event pulses: bit 0 address-decode error, bit 1 host system error |
| cfgFilterBypass | output | 4 | Bus filter bypass controls |
| cfgPort | output | 5 | Port control bits |
| cfgFrameAdj | output | 6 | Frame-length adjustment |
| cfgBigEndian | output | 1 | Byte-order select |
| cfgCoherent | output | 1 | Coherency select |
| cfgBusMaster | output | 1 | Bus-master enable |
| irqOut | output | 1 | Level-sensitive interrupt |

## Verification
Two status-bit collisions are covered. In the first, a hardware event pulse lands in the same access cycle as a write-one-to-clear of the same bit. In the second, an unmapped access with error response enabled sets the address-decode bit while a host-error pulse sets the other bit. The bench provokes the first by raising errEvent during the access phase of the status write, then reads the status back. The bit must still be set, while a bit cleared with no competing pulse drops. The interrupt line is sampled on the two falling edges after each status change, to confirm the one-clock delay.

// File: rtl/usb_cfg_pkg.sv
package usb_cfg_pkg;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int FILT_W  = 4;
  localparam int PORT_W  = 5;
  localparam int FADJ_W  = 6;
  localparam int NUM_SRC = 2;

  localparam logic [FADJ_W-1:0]  FADJ_RST = 6'h20;
  localparam logic [NUM_SRC-1:0] MASK_RST = '1;

  localparam logic [7:0] OFS_FILT   = 8'h30;
  localparam logic [7:0] OFS_PORT   = 8'h34;
  localparam logic [7:0] OFS_FADJ   = 8'h38;
  localparam logic [7:0] OFS_ENDIAN = 8'h40;
  localparam logic [7:0] OFS_COHER  = 8'h44;
  localparam logic [7:0] OFS_BME    = 8'h48;
  localparam logic [7:0] OFS_REGCTL = 8'h60;
  localparam logic [7:0] OFS_STATUS = 8'h64;
  localparam logic [7:0] OFS_MASK   = 8'h68;
  localparam logic [7:0] OFS_IREN   = 8'h6C;
  localparam logic [7:0] OFS_IRDIS  = 8'h70;
  localparam logic [7:0] OFS_SPARE  = 8'h78;

  typedef struct packed {
    logic wrFilt;
    logic wrPort;
    logic wrFadj;
    logic wrEndian;
    logic wrCoher;
    logic wrBme;
    logic wrRegCtl;
    logic wrStatus;
    logic wrIrEn;
    logic wrIrDis;
    logic wrSpare;
    logic decErr;
  } cfgStrb_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_FILT, RD_PORT, RD_FADJ, RD_ENDIAN, RD_COHER, RD_BME,
    RD_REGCTL, RD_STATUS, RD_MASK, RD_ZERO, RD_SPARE
  } rdSel_t;
endpackage

// File: rtl/usb_cfg_ctrl.sv
module usb_cfg_ctrl
  import usb_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [STRB_W-1:0] pStrb,
  input  logic              slvErrEn,
  output cfgStrb_t          strb,
  output rdSel_t            rdSel,
  output logic              pSlvErr
);
  logic   accessPhase;
  logic   wrOk;
  logic   mapped;
  rdSel_t hitSel;

  always_comb begin
    accessPhase = pSel & pEnable;
    wrOk        = accessPhase & pWrite & (&pStrb);
    mapped      = 1'b1;
    hitSel      = RD_NONE;
    unique case (pAddr)
      ADDR_W'(OFS_FILT):   hitSel = RD_FILT;
      ADDR_W'(OFS_PORT):   hitSel = RD_PORT;
      ADDR_W'(OFS_FADJ):   hitSel = RD_FADJ;
      ADDR_W'(OFS_ENDIAN): hitSel = RD_ENDIAN;
      ADDR_W'(OFS_COHER):  hitSel = RD_COHER;
      ADDR_W'(OFS_BME):    hitSel = RD_BME;
      ADDR_W'(OFS_REGCTL): hitSel = RD_REGCTL;
      ADDR_W'(OFS_STATUS): hitSel = RD_STATUS;
      ADDR_W'(OFS_MASK):   hitSel = RD_MASK;
      ADDR_W'(OFS_IREN):   hitSel = RD_ZERO;
      ADDR_W'(OFS_IRDIS):  hitSel = RD_ZERO;
      ADDR_W'(OFS_SPARE):  hitSel = RD_SPARE;
      default:             mapped = 1'b0;
    endcase

    strb          = '0;
    strb.wrFilt   = wrOk && hitSel == RD_FILT;
    strb.wrPort   = wrOk && hitSel == RD_PORT;
    strb.wrFadj   = wrOk && hitSel == RD_FADJ;
    strb.wrEndian = wrOk && hitSel == RD_ENDIAN;
    strb.wrCoher  = wrOk && hitSel == RD_COHER;
    strb.wrBme    = wrOk && hitSel == RD_BME;
    strb.wrRegCtl = wrOk && hitSel == RD_REGCTL;
    strb.wrStatus = wrOk && hitSel == RD_STATUS;
    strb.wrIrEn   = wrOk && pAddr == ADDR_W'(OFS_IREN);
    strb.wrIrDis  = wrOk && pAddr == ADDR_W'(OFS_IRDIS);
    strb.wrSpare  = wrOk && hitSel == RD_SPARE;
    strb.decErr   = accessPhase & ~mapped & slvErrEn;

    rdSel   = (accessPhase & ~pWrite) ? hitSel : RD_NONE;
    pSlvErr = strb.decErr;
  end

  // R2, R10: at most one register is written per access
  assert_onehot_wr_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrFilt, strb.wrPort, strb.wrFadj, strb.wrEndian, strb.wrCoher,
              strb.wrBme, strb.wrRegCtl, strb.wrStatus, strb.wrIrEn, strb.wrIrDis,
              strb.wrSpare}));

  // R10: a partial-strobe access never produces a write strobe
  assert_partial_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pWrite && !(&pStrb)) |->
      !(strb.wrFilt || strb.wrSpare || strb.wrStatus || strb.wrIrEn || strb.wrIrDis));
endmodule

// File: rtl/usb_cfg_dp.sv
module usb_cfg_dp
  import usb_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrb_t           strb,
  input  rdSel_t             rdSel,
  input  logic [DATA_W-1:0]  pWdata,
  input  logic [NUM_SRC-1:0] errEvent,
  output logic [DATA_W-1:0]  pRdata,
  output logic               slvErrEn,
  output logic [FILT_W-1:0]  cfgFilterBypass,
  output logic [PORT_W-1:0]  cfgPort,
  output logic [FADJ_W-1:0]  cfgFrameAdj,
  output logic               cfgBigEndian,
  output logic               cfgCoherent,
  output logic               cfgBusMaster,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] statusQ, statusD;
  logic [NUM_SRC-1:0] maskQ, maskD;
  logic [NUM_SRC-1:0] setVec, clrVec;
  logic [DATA_W-1:0]  spareQ;
  logic               irqQ;

  always_comb begin
    setVec  = errEvent | {{(NUM_SRC-1){1'b0}}, strb.decErr};
    clrVec  = strb.wrStatus ? pWdata[NUM_SRC-1:0] : '0;
    statusD = (statusQ & ~clrVec) | setVec;
    maskD   = maskQ;
    if (strb.wrIrEn)  maskD = maskD & ~pWdata[NUM_SRC-1:0];
    if (strb.wrIrDis) maskD = maskD |  pWdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFilterBypass <= '0;
      cfgPort         <= '0;
      cfgFrameAdj     <= FADJ_RST;
      cfgBigEndian    <= 1'b0;
      cfgCoherent     <= 1'b0;
      cfgBusMaster    <= 1'b1;
      slvErrEn        <= 1'b0;
      spareQ          <= '0;
      statusQ         <= '0;
      maskQ           <= MASK_RST;
      irqQ            <= 1'b0;
    end else begin
      if (strb.wrFilt)   cfgFilterBypass <= pWdata[FILT_W-1:0];
      if (strb.wrPort)   cfgPort         <= pWdata[PORT_W-1:0];
      if (strb.wrFadj)   cfgFrameAdj     <= pWdata[FADJ_W-1:0];
      if (strb.wrEndian) cfgBigEndian    <= pWdata[0];
      if (strb.wrCoher)  cfgCoherent     <= pWdata[0];
      if (strb.wrBme)    cfgBusMaster    <= pWdata[0];
      if (strb.wrRegCtl) slvErrEn        <= pWdata[0];
      if (strb.wrSpare)  spareQ          <= pWdata;
      statusQ <= statusD;
      maskQ   <= maskD;
      irqQ    <= |(statusQ & ~maskQ);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (rdSel)
      RD_FILT:   pRdata = DATA_W'(cfgFilterBypass);
      RD_PORT:   pRdata = DATA_W'(cfgPort);
      RD_FADJ:   pRdata = DATA_W'(cfgFrameAdj);
      RD_ENDIAN: pRdata = DATA_W'(cfgBigEndian);
      RD_COHER:  pRdata = DATA_W'(cfgCoherent);
      RD_BME:    pRdata = DATA_W'(cfgBusMaster);
      RD_REGCTL: pRdata = DATA_W'(slvErrEn);
      RD_STATUS: pRdata = DATA_W'(statusQ);
      RD_MASK:   pRdata = DATA_W'(maskQ);
      RD_SPARE:  pRdata = spareQ;
      default:   pRdata = '0;
    endcase
  end

  // R4, R5: an event pulse always leaves its bit set on the next cycle
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent != '0) |=> ((statusQ & $past(errEvent)) == $past(errEvent)));

  // R4: a status bit only falls after a status write
  assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusQ) & ~statusQ)) |-> $past(strb.wrStatus));

  // R6, R7: the mask moves only on enable/disable writes
  assert_mask_only_via_ctl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ != $past(maskQ)) |-> $past(strb.wrIrEn || strb.wrIrDis));

  // R8: the line rises only after an unmasked pending status
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|(statusQ & ~maskQ)));

  // R9: a decode error is recorded in status bit 0
  assert_decerr_logged_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.decErr |=> statusQ[0]);
endmodule

// File: rtl/usb_host_cfg_regs.sv
module usb_host_cfg_regs
  import usb_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pSel,
  input  logic               pEnable,
  input  logic               pWrite,
  input  logic [ADDR_W-1:0]  pAddr,
  input  logic [31:0]        pWdata,
  input  logic [3:0]         pStrb,
  output logic [31:0]        pRdata,
  output logic               pSlvErr,
  input  logic [1:0]         errEvent,
  output logic [3:0]         cfgFilterBypass,
  output logic [4:0]         cfgPort,
  output logic [5:0]         cfgFrameAdj,
  output logic               cfgBigEndian,
  output logic               cfgCoherent,
  output logic               cfgBusMaster,
  output logic               irqOut
);
  cfgStrb_t strb;
  rdSel_t   rdSel;
  logic     slvErrEn;

  usb_cfg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pStrb(pStrb), .slvErrEn(slvErrEn),
    .strb(strb), .rdSel(rdSel), .pSlvErr(pSlvErr)
  );

  usb_cfg_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .pWdata(pWdata),
    .errEvent(errEvent), .pRdata(pRdata), .slvErrEn(slvErrEn),
    .cfgFilterBypass(cfgFilterBypass), .cfgPort(cfgPort),
    .cfgFrameAdj(cfgFrameAdj), .cfgBigEndian(cfgBigEndian),
    .cfgCoherent(cfgCoherent), .cfgBusMaster(cfgBusMaster), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_usb_host_cfg_regs.sv
`timescale 1ns/1ps
module tb_usb_host_cfg_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [3:0]  pStrb = 4'hF;
  logic [31:0] pRdata;
  logic        pSlvErr;
  logic [1:0]  errEvent = '0;
  logic [3:0]  cfgFilterBypass;
  logic [4:0]  cfgPort;
  logic [5:0]  cfgFrameAdj;
  logic        cfgBigEndian, cfgCoherent, cfgBusMaster, irqOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd;
  logic        er;

  always #10 clk = ~clk;

  usb_host_cfg_regs dut (.*);

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h38, 32'h0,        32'h20,       1'b0, 4'd1},  // R1
    '{1'b0, 8'h48, 32'h0,        32'h1,        1'b0, 4'd1},  // R1
    '{1'b0, 8'h68, 32'h0,        32'h3,        1'b0, 4'd1},  // R1
    '{1'b1, 8'h30, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b0, 8'h30, 32'h0,        32'hF,        1'b0, 4'd2},
    '{1'b1, 8'h34, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd2},
    '{1'b0, 8'h34, 32'h0,        32'h1F,       1'b0, 4'd2},
    '{1'b1, 8'h38, 32'hFFFFFF15, 32'h0,        1'b0, 4'd2},
    '{1'b0, 8'h38, 32'h0,        32'h15,       1'b0, 4'd2},
    '{1'b1, 8'h40, 32'h000000FF, 32'h0,        1'b0, 4'd2},
    '{1'b0, 8'h40, 32'h0,        32'h1,        1'b0, 4'd2},
    '{1'b1, 8'h78, 32'hDEADBEEF, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b0, 8'h78, 32'h0,        32'hDEADBEEF, 1'b0, 4'd3},
    '{1'b1, 8'h68, 32'h0,        32'h0,        1'b0, 4'd6},  // R6
    '{1'b0, 8'h68, 32'h0,        32'h3,        1'b0, 4'd6},
    '{1'b1, 8'h6C, 32'h1,        32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 8'h68, 32'h0,        32'h2,        1'b0, 4'd7},
    '{1'b0, 8'h6C, 32'h0,        32'h0,        1'b0, 4'd7},
    '{1'b0, 8'h50, 32'h0,        32'h0,        1'b0, 4'd9}   // R9 error off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [1:0] ev);
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = w; pAddr = a; pWdata = d; pStrb = s;
    @(negedge clk);
    pEnable = 1'b1; errEvent = ev;
    #2;
    rd = pRdata; er = pSlvErr;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; errEvent = '0; pStrb = 4'hF;
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk);
    errEvent = ev;
    @(negedge clk);
    errEvent = '0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the outputs
    check("R1 filter", 32'(cfgFilterBypass), 32'h0);
    check("R1 frameAdj", 32'(cfgFrameAdj), 32'h20);
    check("R1 busMaster", 32'(cfgBusMaster), 32'h1);
    check("R1 irq", 32'(irqOut), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].wdata, 4'hF, 2'b00);
      if (!VECS[i].wr) check($sformatf("R%0d rd 0x%02h", VECS[i].req, VECS[i].addr), rd, VECS[i].expData);
      check($sformatf("R%0d err 0x%02h", VECS[i].req, VECS[i].addr), 32'(er), 32'(VECS[i].expErr));
    end

    // R2: outputs follow register writes
    check("R2 filter out", 32'(cfgFilterBypass), 32'hF);
    check("R2 port out", 32'(cfgPort), 32'h1F);
    check("R2 fadj out", 32'(cfgFrameAdj), 32'h15);
    check("R2 endian out", 32'(cfgBigEndian), 32'h1);

    // R10: partial strobe write ignored
    xfer(1'b1, 8'h78, 32'h12345678, 4'h3, 2'b00);
    xfer(1'b0, 8'h78, 32'h0, 4'hF, 2'b00);
    check("R10 spare kept", rd, 32'hDEADBEEF);
    xfer(1'b1, 8'h48, 32'h0, 4'h1, 2'b00);
    check("R10 bme kept", 32'(cfgBusMaster), 32'h1);

    // R4/R8: host error while masked (mask now 2'b10) -> no irq
    pulse(2'b10);
    xfer(1'b0, 8'h64, 32'h0, 4'hF, 2'b00);
    check("R4 status set", rd, 32'h2);
    check("R8 masked irq", 32'(irqOut), 32'h0);
    // unmask bit1 via enable, irq one clock after mask changes
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pAddr = 8'h6C; pWdata = 32'h2; pEnable = 1'b0;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0;
    check("R8 irq lag", 32'(irqOut), 32'h0);
    @(negedge clk);
    check("R8 irq high", 32'(irqOut), 32'h1);

    // R5: clear and event on bit1 in same cycle -> stays set
    xfer(1'b1, 8'h64, 32'h2, 4'hF, 2'b10);
    xfer(1'b0, 8'h64, 32'h0, 4'hF, 2'b00);
    check("R5 set wins", rd, 32'h2);
    // R4: plain w1c clears; writing 0 leaves it
    xfer(1'b1, 8'h64, 32'h0, 4'hF, 2'b00);
    xfer(1'b0, 8'h64, 32'h0, 4'hF, 2'b00);
    check("R4 write0 keeps", rd, 32'h2);
    xfer(1'b1, 8'h64, 32'h2, 4'hF, 2'b00);
    xfer(1'b0, 8'h64, 32'h0, 4'hF, 2'b00);
    check("R4 w1c clears", rd, 32'h0);
    @(negedge clk);
    check("R8 irq drops", 32'(irqOut), 32'h0);

    // R9: error response enabled, collides with host error pulse
    xfer(1'b1, 8'h60, 32'h1, 4'hF, 2'b00);
    xfer(1'b0, 8'h5C, 32'h0, 4'hF, 2'b10);
    check("R9 slverr", 32'(er), 32'h1);
    check("R9 rdata zero", rd, 32'h0);
    xfer(1'b0, 8'h64, 32'h0, 4'hF, 2'b00);
    check("R9 decode logged", rd, 32'h3);

    // R7: disable masks all, irq falls
    xfer(1'b1, 8'h70, 32'h3, 4'hF, 2'b00);
    xfer(1'b0, 8'h70, 32'h0, 4'hF, 2'b00);
    check("R7 disable reads 0", rd, 32'h0);
    xfer(1'b0, 8'h68, 32'h0, 4'hF, 2'b00);
    check("R7 mask set", rd, 32'h3);
    check("R8 irq masked", 32'(irqOut), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule